// File: doc/BRIEF.md
# Two-Level Interrupt Priority Controller

This block arbitrates between seven interrupt request sources on behalf of a CPU core. Each source has its own enable bit, gated in turn by a global enable, and a one-bit priority that places it at the low or the high level. Once per machine cycle the controller picks the pending source to service. The high level beats the low level. Within one level a fixed polling order decides.

When the chosen request may preempt the work that is already running, the controller pulses a request to the CPU. In the same cycle it pulses a one-hot acknowledge for the chosen source and it updates a held vector address. Two in-service bits, one per level, record which levels are being serviced. A return strobe from the CPU closes the innermost service, which is the highest active level. The peripherals generate the request flags. The CPU saves its own context.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After synchronous reset, `cpu_irq`, `ack_src`, `ack_level`, `vec_addr` and `in_svc` are all zero.
- R2: A request is serviced only when its enable bit is set and the global enable (`irq_en[7]`) is set. Enable bit positions are: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 UART, 5 timer 2, 6 SPI channel.
- R3: The vector address for each source is: external 0 0x0003, timer 0 0x000B, external 1 0x0013, timer 1 0x001B, UART 0x0023, timer 2 0x002B, SPI channel 0x0043. The address is held until the next service is taken.
- R4: Among admissible requests of the same level, the winner follows the order external 0, SPI channel, timer 0, external 1, timer 1, UART, timer 2, with the highest first.
- R5: A high-level request (priority bit set in `irq_pri[6:0]`, same bit positions as R2) wins over any low-level request. `irq_pri[7]` has no effect.
- R6: While only low level is in service, a new low-level request is not taken and a high-level request is taken.
- R7: While high level is in service, no request is taken.
- R8: A `ret_strobe` pulse clears the highest set in-service bit (`in_svc[1]` = high, `in_svc[0]` = low). When no bit is set, it does nothing.
- R9: Arbitration happens only in cycles where `cyc_tick` is high. No request is taken otherwise.
- R10: A taken request produces, one clock after the tick, a single-cycle `cpu_irq` pulse together with a one-hot `ack_src` (bit = source position per R2) and the `ack_level` of the winner. The in-service bit of that level is set at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_tick | input | 1 | Machine-cycle strobe, arbitration slot |
| irq_req | input | 7 | Request flags, one per source |
| irq_en | input | 8 | Bit 7 global enable, bits 6:0 source enables |
| irq_pri | input | 8 | Bits 6:0 source priority (1 = high), bit 7 unused |
| ret_strobe | input | 1 | Return from service, closes the innermost level |
| cpu_irq | output | 1 | One-cycle interrupt request to the CPU |
| ack_src | output | 7 | One-hot acknowledge of the serviced source |
| ack_level | output | 1 | Level of the serviced source |
| vec_addr | output | 16 | Vector address of the last serviced source |
| in_svc | output | 2 | In-service bits, bit 1 high level, bit 0 low level |

## Verification
The first patterns raise one source at a time. These tell the vector table and the enable bit positions apart, and a set source bit with the global enable clear shows the gating. The patterns with all sources raised have winners removed one by one. They expose the polling order, with the SPI channel second. Mixed priority patterns separate level selection from the polling order. The sequences nest a low service, a high preemption and returns. They distinguish blocked from admitted preemption and show which in-service bit each return clears.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int NSRC  = 7;
    localparam int NLVL  = 2;
    localparam int VEC_W = 16;
    localparam int SRC_W = $clog2(NSRC);

    typedef enum logic [SRC_W-1:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_UART = 3'd4,
        SRC_TMR2 = 3'd5,
        SRC_SPI  = 3'd6
    } src_e;

    typedef struct packed {
        logic             valid;
        logic [SRC_W-1:0] src;
    } pick_t;

    typedef struct packed {
        logic             valid;
        logic             lvl;
        logic [SRC_W-1:0] src;
    } win_t;

    // Polling slot k (0 = first served) to source index
    function automatic logic [SRC_W-1:0] poll_src(input int k);
        case (k)
            0:       poll_src = SRC_EXT0;
            1:       poll_src = SRC_SPI;
            2:       poll_src = SRC_TMR0;
            3:       poll_src = SRC_EXT1;
            4:       poll_src = SRC_TMR1;
            5:       poll_src = SRC_UART;
            default: poll_src = SRC_TMR2;
        endcase
    endfunction

    // Vectors step by 8 from 0x0003, except the SPI channel slot
    function automatic logic [VEC_W-1:0] vec_of(input logic [SRC_W-1:0] s);
        if (s == SRC_SPI)
            vec_of = VEC_W'(16'h0043);
        else
            vec_of = VEC_W'(16'h0003) + VEC_W'({s, 3'b000});
    endfunction

endpackage

// File: rtl/irq_level_pick.sv
module irq_level_pick
    import irq_prio_pkg::*;
#(
    parameter logic LVL = 1'b0
) (
    input  logic [NSRC-1:0] live,
    input  logic [NSRC-1:0] pri,
    output pick_t           pick
);
    always_comb begin
        pick = '0;
        // walk from last to first so the first polling slot wins
        for (int k = NSRC - 1; k >= 0; k--) begin
            logic [SRC_W-1:0] s;
            s = poll_src(k);
            if (live[s] && (pri[s] == LVL)) begin
                pick.valid = 1'b1;
                pick.src   = s;
            end
        end
    end
endmodule

// File: rtl/irq_select.sv
module irq_select
    import irq_prio_pkg::*;
(
    input  logic [NSRC-1:0] req,
    input  logic [NSRC:0]   en,
    input  logic [NSRC-1:0] pri,
    output win_t            win
);
    logic [NSRC-1:0] live;
    pick_t           picks [NLVL];

    assign live = req & en[NSRC-1:0] & {NSRC{en[NSRC]}};

    for (genvar lv = 0; lv < NLVL; lv++) begin : g_lvl
        irq_level_pick #(.LVL(lv[0])) u_pick (
            .live (live),
            .pri  (pri),
            .pick (picks[lv])
        );
    end

    always_comb begin
        if (picks[1].valid)
            win = '{valid: 1'b1, lvl: 1'b1, src: picks[1].src};
        else
            win = '{valid: picks[0].valid, lvl: 1'b0, src: picks[0].src};
    end
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice
    import irq_prio_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            set_en,
    input  logic            set_lvl,
    input  logic            ret,
    output logic [NLVL-1:0] in_svc
);
    logic [NLVL-1:0] cleared;
    logic [NLVL-1:0] set_mask;

    always_comb begin
        cleared = in_svc;
        if (ret) begin
            if (in_svc[1]) cleared[1] = 1'b0;
            else           cleared[0] = 1'b0;
        end
        set_mask = set_en ? (NLVL'(1) << set_lvl) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) in_svc <= '0;
        else     in_svc <= cleared | set_mask;
    end

    // R8: a return with both levels active leaves only the low level
    a_r8_ret_clears_high: assert property (@(posedge clk) disable iff (rst)
        (ret && in_svc == 2'b11) |=> in_svc[0] && !in_svc[1] || in_svc == 2'b11);

    // R8: a return with only low active and nothing new clears it
    a_r8_ret_clears_low: assert property (@(posedge clk) disable iff (rst)
        (ret && in_svc == 2'b01 && !set_en) |=> in_svc == 2'b00);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_tick,
    input  logic [6:0]       irq_req,
    input  logic [7:0]       irq_en,
    input  logic [7:0]       irq_pri,
    input  logic             ret_strobe,
    output logic             cpu_irq,
    output logic [6:0]       ack_src,
    output logic             ack_level,
    output logic [15:0]      vec_addr,
    output logic [1:0]       in_svc
);
    win_t win;
    logic admit;
    logic take;

    irq_select u_sel (
        .req (irq_req),
        .en  (irq_en),
        .pri (irq_pri[NSRC-1:0]),
        .win (win)
    );

    // a request must sit above every level already in service
    assign admit = win.lvl ? !in_svc[1] : (in_svc == '0);
    assign take  = cyc_tick && win.valid && admit;

    irq_inservice u_isv (
        .clk     (clk),
        .rst     (rst),
        .set_en  (take),
        .set_lvl (win.lvl),
        .ret     (ret_strobe),
        .in_svc  (in_svc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_irq   <= 1'b0;
            ack_src   <= '0;
            ack_level <= 1'b0;
            vec_addr  <= '0;
        end else begin
            cpu_irq <= take;
            ack_src <= take ? (NSRC'(1) << win.src) : '0;
            if (take) begin
                ack_level <= win.lvl;
                vec_addr  <= vec_of(win.src);
            end
        end
    end

    a_r10_ack_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_src));

    a_r10_irq_sets_level: assert property (@(posedge clk) disable iff (rst)
        cpu_irq |-> in_svc[ack_level]);

    a_r9_only_on_tick: assert property (@(posedge clk) disable iff (rst)
        cpu_irq |-> $past(cyc_tick));

    a_r7_high_blocks_all: assert property (@(posedge clk) disable iff (rst)
        (in_svc[1] && !ret_strobe) |=> !cpu_irq);

    a_r6_low_blocks_low: assert property (@(posedge clk) disable iff (rst)
        (in_svc == 2'b01 && !ret_strobe) |=> !(cpu_irq && !ack_level));
endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc_tick = 1'b0;
    logic [6:0]  irq_req = '0;
    logic [7:0]  irq_en = '0;
    logic [7:0]  irq_pri = '0;
    logic        ret_strobe = 1'b0;
    logic        cpu_irq;
    logic [6:0]  ack_src;
    logic        ack_level;
    logic [15:0] vec_addr;
    logic [1:0]  in_svc;

    int total = 0;
    int bad   = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .irq_req(irq_req),
        .irq_en(irq_en), .irq_pri(irq_pri), .ret_strobe(ret_strobe),
        .cpu_irq(cpu_irq), .ack_src(ack_src), .ack_level(ack_level),
        .vec_addr(vec_addr), .in_svc(in_svc)
    );

    // expected vector per source position
    function automatic logic [15:0] exp_vec(input int s);
        case (s)
            0: return 16'h0003;
            1: return 16'h000B;
            2: return 16'h0013;
            3: return 16'h001B;
            4: return 16'h0023;
            5: return 16'h002B;
            default: return 16'h0043;
        endcase
    endfunction

    // polling order, first served first
    int poll [7] = '{0, 6, 1, 2, 3, 4, 5};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one arbitration slot; outputs checked after the taking edge
    task automatic tick_once();
        @(negedge clk) cyc_tick = 1'b1;
        @(negedge clk) cyc_tick = 1'b0;
    endtask

    task automatic do_ret();
        @(negedge clk) ret_strobe = 1'b1;
        @(negedge clk) ret_strobe = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 cpu_irq", cpu_irq, 0);
        chk("R1 ack_src", ack_src, 0);
        chk("R1 ack_level", ack_level, 0);
        chk("R1 vec_addr", vec_addr, 0);
        chk("R1 in_svc", in_svc, 0);
    endtask

    task automatic t_vectors();
        irq_pri = 8'h00;
        for (int s = 0; s < 7; s++) begin
            irq_en  = 8'h80 | (8'h01 << s);
            irq_req = 7'h01 << s;
            tick_once();
            chk("R10 cpu_irq pulse", cpu_irq, 1);
            chk("R10 ack one-hot", ack_src, 7'h01 << s);
            chk("R3 vector", vec_addr, exp_vec(s));
            chk("R10 in_svc low", in_svc, 2'b01);
            irq_req = '0;
            @(negedge clk);
            chk("R10 pulse ends", cpu_irq, 0);
            chk("R3 vector held", vec_addr, exp_vec(s));
            do_ret();
            chk("R8 ret clears low", in_svc, 0);
        end
    endtask

    task automatic t_global();
        irq_en = 8'h7F; irq_req = 7'h7F; irq_pri = 8'h00;
        tick_once();
        chk("R2 global off no irq", cpu_irq, 0);
        chk("R2 global off in_svc", in_svc, 0);
        irq_en = 8'h81; irq_req = 7'h02;
        tick_once();
        chk("R2 other bit enabled no irq", cpu_irq, 0);
        chk("R2 other bit in_svc", in_svc, 0);
        irq_req = '0;
    endtask

    task automatic t_poll();
        logic [6:0] pend;
        irq_en = 8'hFF; irq_pri = 8'h00; pend = 7'h7F;
        for (int k = 0; k < 7; k++) begin
            irq_req = pend;
            tick_once();
            chk("R4 polling winner", ack_src, 7'h01 << poll[k]);
            pend[poll[k]] = 1'b0;
            irq_req = pend;
            do_ret();
        end
        irq_req = '0;
    endtask

    task automatic t_level();
        irq_en = 8'hFF; irq_req = 7'h7F; irq_pri = 8'h20;
        tick_once();
        chk("R5 high wins", ack_src, 7'h20);
        chk("R5 high level", ack_level, 1);
        chk("R5 vector", vec_addr, 16'h002B);
        chk("R10 in_svc high", in_svc, 2'b10);
        irq_req = '0;
        do_ret();
        chk("R8 ret clears high", in_svc, 0);
        irq_req = 7'h7F; irq_pri = 8'h80;
        tick_once();
        chk("R5 pri bit7 ignored", ack_src, 7'h01);
        chk("R5 pri bit7 level", ack_level, 0);
        irq_req = '0;
        do_ret();
    endtask

    task automatic t_nest();
        irq_en = 8'hFF; irq_pri = 8'h08;
        irq_req = 7'h04;
        tick_once();
        chk("R6 low taken", ack_src, 7'h04);
        irq_req = 7'h01;
        tick_once();
        chk("R6 low blocks low", cpu_irq, 0);
        chk("R6 in_svc unchanged", in_svc, 2'b01);
        irq_req = 7'h08;
        tick_once();
        chk("R6 high preempts", ack_src, 7'h08);
        chk("R6 in_svc both", in_svc, 2'b11);
        irq_pri = 8'h0A; irq_req = 7'h0A;
        tick_once();
        chk("R7 high blocks high", cpu_irq, 0);
        chk("R7 in_svc kept", in_svc, 2'b11);
        irq_req = '0;
        do_ret();
        chk("R8 highest cleared first", in_svc, 2'b01);
        do_ret();
        chk("R8 then low", in_svc, 2'b00);
        do_ret();
        chk("R8 idle ret no effect", in_svc, 2'b00);
    endtask

    task automatic t_tick();
        irq_en = 8'hFF; irq_pri = 8'h00; irq_req = 7'h7F;
        repeat (5) @(negedge clk);
        chk("R9 no tick no irq", cpu_irq, 0);
        chk("R9 no tick in_svc", in_svc, 0);
        irq_req = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_vectors();
        t_global();
        t_poll();
        t_level();
        t_nest();
        t_tick();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule